// File: doc/BRIEF.md
# Banked Nibble Working-Register File

This block is the working-register store of a small 4-bit processor core. It keeps four banks of eight 4-bit registers. Register names within a bank are Y, Z, W, X, H, L, E and A. Two read ports and one write port can each reach either one 4-bit register or one 8-bit register pair. The block holds a 2-bit bank-select value and a bank-enable flag, and the two together decide which bank every access reaches.

The bank-select value is loaded by its own strobe. The enable flag is set by a separate strobe. While the flag is clear, every access goes to bank 0, whatever bank-select value is stored. Register contents are not reset. The reset input is asserted asynchronously and released through a two-stage synchroniser, which clears the bank-select value and the enable flag.

Top module: `nibble_bank_rf`

## Requirements
- R1: After reset, the stored bank select is 0 and the enable flag is 0, so accesses reach bank 0. Register contents keep their values across reset.
- R2: While the enable flag is 0, the effective bank is bank 0 for every stored bank-select value.
- R3: While the enable flag is 1, the stored 2-bit bank-select value is the effective bank number (0 to 3).
- R4: A bank-select load or an enable-flag load affects accesses from the cycle after its clock edge. A write in the same cycle as a load goes to the previously effective bank.
- R5: A nibble access (pair select 0) uses index 0..7 for Y, Z, W, X, H, L, E, A. A nibble read returns the register in bits 3:0 with bits 7:4 zero, and a nibble write stores write-data bits 3:0.
- R6: A pair access (pair select 1) uses index 0 = E:A, 1 = H:L, 2 = W:X, 3 = Y:Z and 4 = W:L. The first-named register is bits 7:4 and the second is bits 3:0.
- R7: A pair write updates both of its nibbles on one clock edge. A nibble write changes only its addressed register.
- R8: Pair index values 5, 6 and 7 are illegal. A write to them changes no register, and a read of them returns 0.
- R9: The two read ports choose width and index independently, and each returns its data combinationally from the effective bank.
- R10: A write reaches only the effective bank. The same register index in the other banks keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsel_load | input | 1 | Load strobe for the bank-select value |
| bsel_val | input | 2 | Bank-select value to load |
| ben_load | input | 1 | Load strobe for the bank-enable flag |
| ben_val | input | 1 | Bank-enable value to load |
| wr_en | input | 1 | Write enable |
| wr_pair | input | 1 | Write width: 0 nibble, 1 pair |
| wr_idx | input | 3 | Write register or pair index |
| wr_data | input | 8 | Write data (nibble uses bits 3:0) |
| rd0_pair | input | 1 | Read port 0 width |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_data | output | 8 | Read port 0 data |
| rd1_pair | input | 1 | Read port 1 width |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_data | output | 8 | Read port 1 data |

## Verification
The bench uses the default parameters: 4-bit nibbles, eight registers and four banks. With only eight registers per bank and a 3-bit index, random stimulus often reaches the illegal pair codes 5 to 7, the non-adjacent W:L pair and all four banks. Bank loads often fall in the same cycle as writes, which tests the ordering between a load and a write. Directed steps first prime every register, then cover the enable override, the cycle after a load, the pair write, the illegal-code write and retention of contents across reset.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  // Width select used on every access port
  typedef enum logic {ACC_NIB = 1'b0, ACC_PAIR = 1'b1} acc_w_e;

  // Register positions inside a bank
  localparam int unsigned RI_Y = 0;
  localparam int unsigned RI_Z = 1;
  localparam int unsigned RI_W = 2;
  localparam int unsigned RI_X = 3;
  localparam int unsigned RI_H = 4;
  localparam int unsigned RI_L = 5;
  localparam int unsigned RI_E = 6;
  localparam int unsigned RI_A = 7;

  // Pair codes
  localparam int unsigned PC_EA = 0;
  localparam int unsigned PC_HL = 1;
  localparam int unsigned PC_WX = 2;
  localparam int unsigned PC_YZ = 3;
  localparam int unsigned PC_WL = 4;
endpackage

// File: rtl/nrf_rst_sync.sv
module nrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/nrf_bank_ctrl.sv
module nrf_bank_ctrl #(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              bsel_load,
  input  logic [BANK_W-1:0] bsel_val,
  input  logic              ben_load,
  input  logic              ben_val,
  output logic [BANK_W-1:0] eff_bank
);
  logic [BANK_W-1:0] bsel_q, bsel_d;
  logic              ben_q, ben_d;

  always_comb begin
    bsel_d = bsel_q;
    ben_d  = ben_q;
    if (bsel_load) bsel_d = bsel_val;
    if (ben_load)  ben_d  = ben_val;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      bsel_q <= '0;
      ben_q  <= 1'b0;
    end else begin
      bsel_q <= bsel_d;
      ben_q  <= ben_d;
    end
  end

  assign eff_bank = ben_q ? bsel_q : '0;

  // R2
  flag_clear_bank0_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ben_load && !ben_val) |=> (eff_bank == '0));

  // R3
  direct_select_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (ben_load && ben_val && bsel_load) |=> (eff_bank == $past(bsel_val)));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (!bsel_load && !ben_load) |=> $stable(eff_bank));
endmodule

// File: rtl/nrf_pair_decode.sv
module nrf_pair_decode #(
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0] code,
  output logic [IDX_W-1:0] hi_reg,
  output logic [IDX_W-1:0] lo_reg,
  output logic             legal
);
  import nrf_pkg::*;

  always_comb begin
    hi_reg = '0;
    lo_reg = '0;
    legal  = 1'b1;
    case (int'(code))
      PC_EA:   begin hi_reg = IDX_W'(RI_E); lo_reg = IDX_W'(RI_A); end
      PC_HL:   begin hi_reg = IDX_W'(RI_H); lo_reg = IDX_W'(RI_L); end
      PC_WX:   begin hi_reg = IDX_W'(RI_W); lo_reg = IDX_W'(RI_X); end
      PC_YZ:   begin hi_reg = IDX_W'(RI_Y); lo_reg = IDX_W'(RI_Z); end
      PC_WL:   begin hi_reg = IDX_W'(RI_W); lo_reg = IDX_W'(RI_L); end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/nibble_bank_rf.sv
module nibble_bank_rf #(
  parameter int unsigned NIB_W     = 4,
  parameter int unsigned NUM_REGS  = 8,
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS),
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned PAIR_W   = 2 * NIB_W,
  localparam int unsigned DEPTH    = NUM_REGS * NUM_BANKS,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned NRD      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bsel_load,
  input  logic [BANK_W-1:0] bsel_val,
  input  logic              ben_load,
  input  logic              ben_val,
  input  logic              wr_en,
  input  logic              wr_pair,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PAIR_W-1:0] wr_data,
  input  logic              rd0_pair,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [PAIR_W-1:0] rd0_data,
  input  logic              rd1_pair,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [PAIR_W-1:0] rd1_data
);
  import nrf_pkg::*;

  logic              rst_sn;
  logic [BANK_W-1:0] eff_bank;
  logic [NIB_W-1:0]  mem [DEPTH];

  nrf_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  nrf_bank_ctrl #(.NUM_BANKS(NUM_BANKS)) i_bank_ctrl (
    .clk(clk), .rst_sn(rst_sn),
    .bsel_load(bsel_load), .bsel_val(bsel_val),
    .ben_load(ben_load), .ben_val(ben_val),
    .eff_bank(eff_bank)
  );

  // ---------------- write path ----------------
  logic [IDX_W-1:0]  wp_hi, wp_lo;
  logic              wp_legal;
  logic              we_hi, we_lo;
  logic [ADDR_W-1:0] wa_hi, wa_lo;
  logic [NIB_W-1:0]  wd_hi, wd_lo;

  nrf_pair_decode #(.NUM_REGS(NUM_REGS)) i_wr_dec (
    .code(wr_idx), .hi_reg(wp_hi), .lo_reg(wp_lo), .legal(wp_legal)
  );

  always_comb begin
    we_hi = 1'b0;
    we_lo = 1'b0;
    wa_hi = {eff_bank, wp_hi};
    wa_lo = {eff_bank, wr_idx};
    wd_hi = wr_data[PAIR_W-1:NIB_W];
    wd_lo = wr_data[NIB_W-1:0];
    if (wr_en && rst_sn) begin
      if (acc_w_e'(wr_pair) == ACC_PAIR) begin
        we_hi = wp_legal;
        we_lo = wp_legal;
        wa_lo = {eff_bank, wp_lo};
      end else begin
        we_lo = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we_hi) mem[wa_hi] <= wd_hi;
    if (we_lo) mem[wa_lo] <= wd_lo;
  end

  // ---------------- read ports ----------------
  logic              rp_pair [NRD];
  logic [IDX_W-1:0]  rp_idx  [NRD];
  logic [PAIR_W-1:0] rp_data [NRD];

  assign rp_pair[0] = rd0_pair;
  assign rp_idx[0]  = rd0_idx;
  assign rp_pair[1] = rd1_pair;
  assign rp_idx[1]  = rd1_idx;
  assign rd0_data   = rp_data[0];
  assign rd1_data   = rp_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [IDX_W-1:0] hi_r, lo_r;
    logic             legal;

    nrf_pair_decode #(.NUM_REGS(NUM_REGS)) i_rd_dec (
      .code(rp_idx[p]), .hi_reg(hi_r), .lo_reg(lo_r), .legal(legal)
    );

    always_comb begin
      if (acc_w_e'(rp_pair[p]) == ACC_PAIR) begin
        rp_data[p] = legal ? {mem[{eff_bank, hi_r}], mem[{eff_bank, lo_r}]} : '0;
      end else begin
        rp_data[p] = {{NIB_W{1'b0}}, mem[{eff_bank, rp_idx[p]}]};
      end
    end
  end

  // R5
  nib_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !rd0_pair |-> (rd0_data[PAIR_W-1:NIB_W] == '0));

  // R8
  illegal_pair_rd_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd1_pair && (int'(rd1_idx) > PC_WL)) |-> (rd1_data == '0));

  // R7
  pair_two_nibble_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (we_hi || we_lo) |-> (acc_w_e'(wr_pair) == ACC_PAIR ? (we_hi && we_lo && (wa_hi != wa_lo)) : !we_hi));
endmodule

// File: tb/test_nibble_bank_rf.sv
module test_nibble_bank_rf;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bsel_load, ben_load, ben_val, wr_en, wr_pair, rd0_pair, rd1_pair;
  logic [1:0] bsel_val;
  logic [2:0] wr_idx, rd0_idx, rd1_idx;
  logic [7:0] wr_data, rd0_data, rd1_data;

  int checks = 0;
  int failures = 0;

  logic [3:0] mdl [4][8];
  int         m_bsel = 0;
  bit         m_ben = 1'b0;

  const int hi_tab [5] = '{6, 4, 2, 0, 2};
  const int lo_tab [5] = '{7, 5, 3, 1, 5};

  always #2 clk = ~clk;

  nibble_bank_rf i_nibble_bank_rf (
    .clk(clk), .rst_n(rst_n),
    .bsel_load(bsel_load), .bsel_val(bsel_val),
    .ben_load(ben_load), .ben_val(ben_val),
    .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd0_pair(rd0_pair), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_pair(rd1_pair), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
  );

  function automatic int eff_b();
    return m_ben ? m_bsel : 0;
  endfunction

  function automatic logic [7:0] exp_rd(bit pr, int ix);
    int b = eff_b();
    if (!pr) return {4'h0, mdl[b][ix]};
    if (ix > 4) return 8'h00;
    return {mdl[b][hi_tab[ix]], mdl[b][lo_tab[ix]]};
  endfunction

  function automatic string auto_tag(bit pr, int ix);
    if (pr && ix > 4) return "R8";
    if (pr) return "R6";
    return "R5";
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit bl, bit [1:0] bv, bit el, bit ev,
                      bit we, bit wp, bit [2:0] wi, bit [7:0] wd,
                      bit p0, bit [2:0] i0, bit p1, bit [2:0] i1,
                      string tag, bit do_chk);
    @(negedge clk);
    bsel_load = bl; bsel_val = bv; ben_load = el; ben_val = ev;
    wr_en = we; wr_pair = wp; wr_idx = wi; wr_data = wd;
    rd0_pair = p0; rd0_idx = i0; rd1_pair = p1; rd1_idx = i1;
    #1;
    if (do_chk) begin
      chk(rd0_data, exp_rd(p0, int'(i0)), (tag != "") ? tag : auto_tag(p0, int'(i0)));
      chk(rd1_data, exp_rd(p1, int'(i1)), (tag != "") ? tag : {"R9 ", auto_tag(p1, int'(i1))});
    end
    @(posedge clk);
    if (we) begin
      int b = eff_b();
      if (!wp) mdl[b][wi] = wd[3:0];
      else if (wi <= 4) begin
        mdl[b][hi_tab[wi]] = wd[7:4];
        mdl[b][lo_tab[wi]] = wd[3:0];
      end
    end
    if (bl) m_bsel = int'(bv);
    if (el) m_ben = ev;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    bsel_load = 0; bsel_val = 0; ben_load = 0; ben_val = 0;
    wr_en = 0; wr_pair = 0; wr_idx = 0; wr_data = 0;
    rd0_pair = 0; rd0_idx = 0; rd1_pair = 0; rd1_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // Prime every register of every bank (R3, R10)
    for (int b = 0; b < 4; b++) begin
      step(1, 2'(b), 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
      for (int r = 0; r < 8; r++)
        step(0, 0, 0, 0, 1, 0, 3'(r), 8'($urandom_range(255)), 0, 0, 0, 0, "", 1'b0);
    end
    // R3: bank 3 is effective, read all nibbles
    for (int r = 0; r < 8; r++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'(r), 0, 3'(7 - r), "R3", 1'b1);

    // R2: flag cleared with bank select still 3 -> bank 0
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 1, 3'd0, "R2", 1'b1);

    // R4: load bank 1 with flag, write same cycle -> bank 0
    step(1, 2'd1, 1, 1, 1, 0, 3'd0, 8'h0A, 0, 0, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 1, 3'd3, "R4", 1'b1);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 3'd0, "R4", 1'b1);
    chk(rd0_data, 8'h0A, "R4");

    // R7: pair write W:L in bank 0, neighbours unchanged
    step(0, 0, 0, 0, 1, 1, 3'd4, 8'h3C, 0, 0, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd2, 0, 3'd5, "R7", 1'b1);
    chk({rd0_data[3:0], rd1_data[3:0]}, 8'h3C, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd3, 1, 3'd4, "R7", 1'b1);
    // R7: nibble write changes only its register
    step(0, 0, 0, 0, 1, 0, 3'd5, 8'hF7, 1, 3'd1, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd4, 0, 3'd2, "R7", 1'b1);

    // R8: illegal pair writes ignored
    for (int c = 5; c < 8; c++) step(0, 0, 0, 0, 1, 1, 3'(c), 8'hFF, 0, 0, 0, 0, "", 1'b0);
    for (int r = 0; r < 8; r++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'(r), 1, 3'(r), "R8", 1'b1);

    // R10: write in bank 2, other banks keep same index
    step(1, 2'd2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
    step(0, 0, 0, 0, 1, 0, 3'd6, 8'h05, 0, 0, 0, 0, "", 1'b0);
    for (int b = 0; b < 4; b++) begin
      step(1, 2'(b), 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'd6, 1, 3'd0, "R10", 1'b1);
    end

    // Random mix (R2..R10)
    for (int n = 0; n < 600; n++) begin
      step(($urandom_range(3) == 0), 2'($urandom_range(3)),
           ($urandom_range(3) == 0), 1'($urandom_range(1)),
           1'($urandom_range(1)), 1'($urandom_range(1)),
           3'($urandom_range(7)), 8'($urandom_range(255)),
           1'($urandom_range(1)), 3'($urandom_range(7)),
           1'($urandom_range(1)), 3'($urandom_range(7)), "", 1'b1);
    end

    // R1: select bank 2 with flag, then reset -> bank 0, contents kept
    step(1, 2'd2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "", 1'b0);
    @(negedge clk) rst_n = 1'b0;
    m_bsel = 0; m_ben = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    for (int r = 0; r < 8; r++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3'(r), 1, 3'(r % 5), "R1", 1'b1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule